// File: doc/BRIEF.md
# Signed Integer Divider, Four Quotient Bits per Cycle

This block divides one 32-bit two's-complement integer by another and returns either the quotient or the remainder. It serves integer divide and modulo instructions. The caller presents dividend and divisor and chooses which of the two results it wants. It then pulses a start strobe and waits for a one-cycle done pulse. At that pulse the result and an error flag are valid, and both hold until the next accepted start.

Inside, both operands are first split into a sign and a magnitude. A restoring recurrence then runs on the magnitudes. A single register holds the partial remainder in its upper half and the growing quotient in its lower half. Each clock passes this register through a chain of four compare-and-subtract steps, so every cycle settles four quotient bits. One cycle captures the operands and eight cycles iterate. After that the signs are put back and the selected value is registered to the output.

Two operand patterns are illegal. A zero divisor and the most negative dividend over minus one both raise the error flag, and neither changes the latency.

Top module: `sdiv16_radix`

## Requirements
- R1: With the quotient selected (`want_rem_i`=0), the result is the dividend divided by the divisor, truncated toward zero. Its sign is negative exactly when the operand signs differ and the quotient is non-zero.
- R2: With the remainder selected (`want_rem_i`=1), the result r satisfies dividend = quotient*divisor + r, takes the sign of the dividend, and has a magnitude below that of the divisor.
- R3: `done_o` rises on the ninth rising clock edge, counting the edge that samples `start_i` high as the first.
- R4: `done_o` stays high for exactly one clock cycle per accepted start.
- R5: A `start_i` pulse that arrives while a division is running is ignored. The running division finishes with its own operands and its own latency.
- R6: A zero divisor sets `err_o`=1 and returns 0 for either selection, after the normal latency.
- R7: The dividend 0x80000000 over the divisor 0xFFFFFFFF (-1) gives 0x80000000 with `err_o`=1 when the quotient is selected. It gives 0 with `err_o`=0 when the remainder is selected.
- R8: For every other operand pair `err_o` is 0. `res_o` and `err_o` keep their value from one done pulse until the next accepted start completes.
- R9: After reset, `res_o` is 0, `done_o` is 0 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a division; sampled only while idle |
| want_rem_i | input | 1 | 0 selects the quotient, 1 selects the remainder |
| dvd_i | input | 32 | Dividend, two's complement |
| dvs_i | input | 32 | Divisor, two's complement |
| res_o | output | 32 | Selected result, two's complement |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| err_o | output | 1 | Illegal division flag, valid from done onward |

## Verification
The bench builds the block with its defaults: a 32-bit word and four bits per step, which gives eight iterations. At this width the extreme operands can be reached directly. These are 0x80000000 as dividend, divisor and negated quotient, divisors of plus and minus one, and divisors larger than the dividend. Both the corner cases and a few hundred random pairs are compared against results computed in the bench. The bench also counts the cycles to each done pulse. This exposes any change in the iteration count or any reload caused by a start pulse that arrives mid-run.

// File: rtl/sdiv16_pkg.sv
package sdiv16_pkg;
  // Per-division context captured when the operands are loaded
  typedef struct packed {
    logic q_neg;     // quotient must be negated
    logic r_neg;     // remainder must be negated
    logic by_zero;   // divisor was zero
    logic min_m1;    // most negative dividend over minus one
    logic want_rem;  // remainder selected
  } sdiv_ctx_t;
endpackage

// File: rtl/sdiv16_mag.sv
module sdiv16_mag #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o
);
  always_comb begin
    neg_o = val_i[W-1];
    mag_o = neg_o ? (~val_i + W'(1)) : val_i;
  end
endmodule

// File: rtl/sdiv16_step.sv
module sdiv16_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] shifted;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    shifted = {rem_i, quo_i[W-1]};
    diff    = shifted - {1'b0, dvs_i};
    fits    = ~diff[W];
    rem_o   = fits ? diff[W-1:0] : shifted[W-1:0];
    quo_o   = {quo_i[W-2:0], fits};
  end
endmodule

// File: rtl/sdiv16_ctrl.sv
module sdiv16_ctrl #(
  parameter int ITERS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          done_q, done_n;

  always_comb begin
    load_o = start_i & ~busy_q;
    step_o = busy_q;
    last_o = busy_q & (cnt_q == CW'(ITERS - 1));
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (load_o) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (busy_q) begin
      cnt_n = cnt_q + CW'(1);
      if (last_o) busy_n = 1'b0;
    end
    done_n = last_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R4: done is a single-cycle pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5: a running division advances one step per cycle; start cannot reload it
  assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != CW'(ITERS - 1)) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));

  // R3: done follows only the final iteration
  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(busy_q) && !busy_q));
endmodule

// File: rtl/sdiv16_radix.sv
module sdiv16_radix #(
  parameter int W     = 32,
  parameter int DIGIT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         want_rem_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] res_o,
  output logic         done_o,
  output logic         err_o
);
  import sdiv16_pkg::*;

  localparam int ITERS = W / DIGIT;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic load_w, step_w, last_w, busy_w;

  sdiv16_ctrl #(.ITERS(ITERS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load_w), .step_o(step_w), .last_o(last_w),
    .busy_o(busy_w), .done_o(done_o)
  );

  // operand conversion
  logic         a_neg, b_neg;
  logic [W-1:0] a_mag, b_mag;

  sdiv16_mag #(.W(W)) mag_a_i (.val_i(dvd_i), .neg_o(a_neg), .mag_o(a_mag));
  sdiv16_mag #(.W(W)) mag_b_i (.val_i(dvs_i), .neg_o(b_neg), .mag_o(b_mag));

  // combined remainder/quotient shift register and divisor magnitude
  logic [2*W-1:0] acc_q, acc_n;
  logic [W-1:0]   dmag_q, dmag_n;
  sdiv_ctx_t      ctx_q, ctx_n;
  logic [W-1:0]   res_q, res_n;
  logic           err_q, err_n;

  // chain of restoring steps
  logic [W-1:0] r_ch [0:DIGIT];
  logic [W-1:0] q_ch [0:DIGIT];

  assign r_ch[0] = acc_q[2*W-1:W];
  assign q_ch[0] = acc_q[W-1:0];

  for (genvar g = 0; g < DIGIT; g++) begin : g_step
    sdiv16_step #(.W(W)) step_i (
      .rem_i(r_ch[g]), .quo_i(q_ch[g]), .dvs_i(dmag_q),
      .rem_o(r_ch[g+1]), .quo_o(q_ch[g+1])
    );
  end

  // sign restoration on the final chain output
  logic [W-1:0] q_fin, r_fin, q_sgn, r_sgn;

  always_comb begin
    q_fin = q_ch[DIGIT];
    r_fin = r_ch[DIGIT];
    q_sgn = ctx_q.q_neg ? (~q_fin + W'(1)) : q_fin;
    r_sgn = ctx_q.r_neg ? (~r_fin + W'(1)) : r_fin;
  end

  // next state
  always_comb begin
    acc_n  = acc_q;
    dmag_n = dmag_q;
    ctx_n  = ctx_q;
    res_n  = res_q;
    err_n  = err_q;
    if (load_w) begin
      acc_n          = {{W{1'b0}}, a_mag};
      dmag_n         = b_mag;
      ctx_n.q_neg    = a_neg ^ b_neg;
      ctx_n.r_neg    = a_neg;
      ctx_n.by_zero  = (dvs_i == '0);
      ctx_n.min_m1   = (dvd_i == MOST_NEG) && (dvs_i == '1);
      ctx_n.want_rem = want_rem_i;
    end else if (step_w) begin
      acc_n = {r_ch[DIGIT], q_ch[DIGIT]};
    end
    if (last_w) begin
      if (ctx_q.by_zero) begin
        res_n = '0;
        err_n = 1'b1;
      end else begin
        res_n = ctx_q.want_rem ? r_sgn : q_sgn;
        err_n = ctx_q.min_m1 & ~ctx_q.want_rem;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      dmag_q <= '0;
      ctx_q  <= '0;
      res_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      acc_q  <= acc_n;
      dmag_q <= dmag_n;
      ctx_q  <= ctx_n;
      res_q  <= res_n;
      err_q  <= err_n;
    end
  end

  assign res_o = res_q;
  assign err_o = err_q;

  // R2: partial remainder stays below the divisor throughout the recurrence
  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && dmag_q != '0) |-> (acc_q[2*W-1:W] < dmag_q));

  // R6: zero divisor reports error and zero
  assert_zero_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ctx_q.by_zero) |-> (res_o == '0 && err_o));

  // R7: overflow on the quotient path returns the most negative value
  assert_min_over_m1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ctx_q.min_m1 && !ctx_q.want_rem) |-> (res_o == MOST_NEG && err_o));

  // R8: outputs hold while idle without a start
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && !start_i) |=> ($stable(res_o) && $stable(err_o)));
endmodule

// File: tb/sdiv16_radix_tb_top.sv
`timescale 1ns/1ps
module sdiv16_radix_tb_top;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic         want_rem_i;
  logic [W-1:0] dvd_i;
  logic [W-1:0] dvs_i;
  logic [W-1:0] res_o;
  logic         done_o;
  logic         err_o;

  sdiv16_radix #(.W(W), .DIGIT(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .want_rem_i(want_rem_i),
    .dvd_i(dvd_i), .dvs_i(dvs_i), .res_o(res_o), .done_o(done_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic [W-1:0] res;
    logic         err;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [W-1:0] last_res;
  logic         last_err;

  task automatic report(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // expected outcome computed from the requirements
  function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, bit rem, string tag);
    exp_t e;
    int sa, sb;
    sa = int'(a);
    sb = int'(b);
    e.tag = tag;
    if (b == '0) begin
      e.res = '0; e.err = 1'b1;                        // R6
    end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      e.res = rem ? '0 : 32'h8000_0000; e.err = ~rem;  // R7
    end else begin
      e.res = rem ? W'(sa % sb) : W'(sa / sb);         // R1 / R2
      e.err = 1'b0;                                    // R8
    end
    return e;
  endfunction

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        report(1'b0, "R4", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        report(res_o == e.res, e.tag, "result", res_o, e.res);
        report(err_o == e.err, e.tag, "error flag", err_o, e.err);
      end
    end
  end

  // driver: issues one division, optionally injects a start while busy
  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, bit rem, string tag,
                        bit inject = 0);
    int n;
    exp_t e;
    e = model(a, b, rem, tag);
    @(negedge clk);
    dvd_i = a; dvs_i = b; want_rem_i = rem; start_i = 1'b1;
    exp_q.push_back(e);
    n = 0;
    while (n < 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1) begin
        start_i = 1'b0;
        dvd_i = $urandom; dvs_i = $urandom; want_rem_i = ~rem;
      end
      if (inject && n == 3) start_i = 1'b1;  // R5: ignored while busy
      if (inject && n == 4) start_i = 1'b0;
      if (done_o) break;
    end
    report(n == 9, "R3", "cycles to done", n, 9);
    @(negedge clk);
    report(done_o == 1'b0, "R4", "done width", done_o, 0);
    last_res = e.res;
    last_err = e.err;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; want_rem_i = 1'b0; dvd_i = '0; dvs_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    report(res_o == '0, "R9", "reset result", res_o, 0);
    report(done_o == 1'b0, "R9", "reset done", done_o, 0);
    report(err_o == 1'b0, "R9", "reset error", err_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: quotient in all sign combinations
    run_op(32'd100, 32'd7, 0, "R1");
    run_op(-32'sd100, 32'd7, 0, "R1");
    run_op(32'd100, -32'sd7, 0, "R1");
    run_op(-32'sd100, -32'sd7, 0, "R1");
    run_op(32'd5, 32'd9, 0, "R1");
    run_op(32'h7FFF_FFFF, 32'd1, 0, "R1");
    run_op(32'h8000_0000, 32'd1, 0, "R1");
    run_op(32'h8000_0000, 32'h8000_0000, 0, "R1");
    run_op(32'd3, 32'h8000_0000, 0, "R1");
    // R2: remainder
    run_op(32'd100, 32'd7, 1, "R2");
    run_op(-32'sd100, 32'd7, 1, "R2");
    run_op(32'd100, -32'sd7, 1, "R2");
    run_op(-32'sd100, -32'sd7, 1, "R2");
    run_op(32'h8000_0000, 32'd3, 1, "R2");
    run_op(32'h7FFF_FFFF, 32'h8000_0000, 1, "R2");
    // R6: zero divisor
    run_op(32'd1234, 32'd0, 0, "R6");
    run_op(-32'sd1234, 32'd0, 1, "R6");
    // R7: most negative over minus one
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 0, "R7");
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1, "R7");
    // R5: start while busy is ignored
    run_op(32'd999, 32'd10, 0, "R5", 1);
    run_op(-32'sd77, 32'd5, 1, "R5", 1);

    // R8: outputs hold while idle, inputs wiggling, start low
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      dvd_i = $urandom; dvs_i = $urandom; want_rem_i = $urandom;
    end
    report(res_o == last_res, "R8", "held result", res_o, last_res);
    report(err_o == last_err, "R8", "held error", err_o, last_err);

    // R1/R2: random operands
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = (i % 3 == 0) ? W'($urandom % 300) - W'(150) : W'($urandom);
      run_op(a, b, i[0], i[0] ? "R2" : "R1");
    end

    repeat (3) @(negedge clk);
    report(exp_q.size() == 0, "R4", "pending results", exp_q.size(), 0);
    wrap_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end
endmodule